// File: doc/BRIEF.md
# Interrupt Destination Router

This block turns one interrupt request into the set of local interrupt controllers that must receive it. A request is either a command word pair written by a sending agent or a message-signalled write (an address and a data word). The block pulls the destination, the destination mode, the delivery mode, the vector and the trigger mode out of either format. It then builds an N-bit agent mask. The mask comes from physical ID matching, from flat or cluster logical matching, or from a command shorthand. When the delivery mode asks for lowest priority, the mask is reduced to a single agent.

Each agent's physical ID, logical ID and logical model nibble arrive as packed input vectors. Bits are grouped per agent, with agent 0 in the least significant group. The result goes out on a registered valid/ready stream together with the forwarded vector, delivery mode and trigger mode. A flag marks a request that reached no agent.

Back-pressure works like this. The output stage holds one result. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high when the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new request is taken.

Top module: `irq_route_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1. A request accepted on a clock edge appears on the outputs with `out_valid` high right after that same edge.
- R2: `req_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, all outputs hold their values, and the held request leaves only after `out_ready` rises.
- R3: In physical destination mode (mode bit 0), destination 8'hFF selects every agent.
- R4: In physical mode with any other destination, the mask holds only the lowest-indexed agent whose physical ID equals the destination. If no agent matches, the mask is empty.
- R5: In logical mode (mode bit 1), an agent with model nibble 4'hF is selected when the bitwise AND of the destination and its logical ID is nonzero.
- R6: In logical mode, an agent with model nibble 4'h0 is selected when the high nibbles of the destination and its logical ID are equal and their low nibbles share a set bit. An agent with any other model nibble is never selected by logical matching.
- R7: For a command request (`req_kind`=0), `req_data[19:18]` picks the mask source: 0 uses destination matching, 1 selects the sender `req_sender` only, 2 selects all agents, and 3 selects all agents except the sender. For a message-signalled request these bits have no effect.
- R8: When the delivery mode is 3'b001 (lowest priority), only the lowest-indexed bit of the computed mask is kept.
- R9: A command request decodes as follows: vector from `req_data[7:0]`, delivery mode from `req_data[10:8]`, destination mode from `req_data[11]`, trigger mode from `req_data[15]`, and destination from `req_addr[31:24]`.
- R10: A message-signalled request (`req_kind`=1) decodes as follows: destination from `req_addr[19:12]`, destination mode from `req_addr[2]`, vector from `req_data[7:0]`, delivery mode from `req_data[10:8]`, and trigger mode from `req_data[15]`.
- R11: `out_no_target` is 1 with a result whose mask is all zero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 1 | 0 = command word pair, 1 = message-signalled write |
| req_addr | input | 32 | High command word, or message address |
| req_data | input | 32 | Low command word, or message data |
| req_sender | input | $clog2(N) | Index of the agent sending a command |
| agent_phys_id | input | 8*N | Physical ID of each agent |
| agent_log_id | input | 8*N | Logical ID of each agent |
| agent_model | input | 4*N | Logical model nibble of each agent |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_mask | output | N | Agents that receive the interrupt |
| out_vector | output | 8 | Forwarded vector |
| out_dmode | output | 3 | Forwarded delivery mode |
| out_trig | output | 1 | Forwarded trigger mode |
| out_no_target | output | 1 | Result reached no agent |

## Verification
The whole result is written into one register in one cycle. A mistake in decoding or matching therefore shows as a wrong mask bit or a wrong field on the very next `out_valid`, and nothing is hidden in state carried between requests. A stall fault is the only error that builds up over time. It shows as an output that changes, or a second request taken, while `out_ready` is held low. The sweeps cover every destination byte in both modes and for both request formats, plus every shorthand and sender pair. Any single bad match term therefore shows up within one request.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [2:0] DM_LOWPRI     = 3'b001;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_ALL      = 8'hFF;

  typedef enum logic [1:0] {
    SH_ADDRESSED = 2'd0,
    SH_SELF      = 2'd1,
    SH_ALL       = 2'd2,
    SH_OTHERS    = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       logical;
    shorthand_e shorthand;
    logic [2:0] dmode;
    logic [7:0] vector;
    logic       trig;
  } irq_fields_t;

endpackage

// File: rtl/irq_msg_decode.sv
module irq_msg_decode
  import irq_route_pkg::*;
(
  input  logic        kind,
  input  logic [31:0] addr,
  input  logic [31:0] data,
  output irq_fields_t fields
);
  // both formats share the vector, delivery-mode and trigger positions
  always_comb begin
    fields.vector = data[7:0];
    fields.dmode  = data[10:8];
    fields.trig   = data[15];
    if (kind) begin
      fields.dest      = addr[19:12];
      fields.logical   = addr[2];
      fields.shorthand = SH_ADDRESSED;
    end else begin
      fields.dest      = addr[31:24];
      fields.logical   = data[11];
      fields.shorthand = shorthand_e'(data[19:18]);
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_in,
  output logic [W-1:0] vec_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] twos;
  // two's complement isolates the least significant set bit
  assign twos    = ~vec_in + ONE;
  assign vec_out = vec_in & twos;
endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import irq_route_pkg::*;
#(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  irq_fields_t       fields,
  input  logic [IDXW-1:0]   sender,
  input  logic [8*N-1:0]    phys_id,
  input  logic [8*N-1:0]    log_id,
  input  logic [4*N-1:0]    model,
  output logic [N-1:0]      mask
);
  logic [N-1:0] phys_hit, phys_first, log_hit, self_bit;

  for (genvar i = 0; i < N; i++) begin : g_agent
    logic [7:0] lid;
    logic [3:0] mdl;
    assign lid = log_id[8*i +: 8];
    assign mdl = model[4*i +: 4];
    assign phys_hit[i] = (phys_id[8*i +: 8] == fields.dest);
    always_comb begin
      unique case (mdl)
        MODEL_FLAT:    log_hit[i] = |(fields.dest & lid);
        MODEL_CLUSTER: log_hit[i] = (fields.dest[7:4] == lid[7:4]) &&
                                    (|(fields.dest[3:0] & lid[3:0]));
        default:       log_hit[i] = 1'b0;
      endcase
    end
    assign self_bit[i] = (sender == IDXW'(i));
  end

  irq_lowest_pick #(.W(N)) u_phys_first (
    .vec_in  (phys_hit),
    .vec_out (phys_first)
  );

  always_comb begin
    unique case (fields.shorthand)
      SH_SELF:   mask = self_bit;
      SH_ALL:    mask = '1;
      SH_OTHERS: mask = ~self_bit;
      default: begin
        if (fields.logical)               mask = log_hit;
        else if (fields.dest == DEST_ALL) mask = '1;
        else                              mask = phys_first;
      end
    endcase
  end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_kind,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_data,
  input  logic [IDXW-1:0]  req_sender,
  input  logic [8*N-1:0]   agent_phys_id,
  input  logic [8*N-1:0]   agent_log_id,
  input  logic [4*N-1:0]   agent_model,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N-1:0]     out_mask,
  output logic [7:0]       out_vector,
  output logic [2:0]       out_dmode,
  output logic             out_trig,
  output logic             out_no_target
);
  irq_fields_t  fields;
  logic [N-1:0] raw_mask, low_mask, final_mask;
  logic         req_fire;

  irq_msg_decode u_decode (
    .kind   (req_kind),
    .addr   (req_addr),
    .data   (req_data),
    .fields (fields)
  );

  irq_dest_match #(.N(N), .IDXW(IDXW)) u_match (
    .fields  (fields),
    .sender  (req_sender),
    .phys_id (agent_phys_id),
    .log_id  (agent_log_id),
    .model   (agent_model),
    .mask    (raw_mask)
  );

  irq_lowest_pick #(.W(N)) u_lowpri (
    .vec_in  (raw_mask),
    .vec_out (low_mask)
  );

  assign final_mask = (fields.dmode == DM_LOWPRI) ? low_mask : raw_mask;
  assign req_ready  = !out_valid || out_ready;
  assign req_fire   = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      out_vector    <= '0;
      out_dmode     <= '0;
      out_trig      <= 1'b0;
      out_no_target <= 1'b0;
    end else if (req_ready) begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask      <= final_mask;
        out_vector    <= fields.vector;
        out_dmode     <= fields.dmode;
        out_trig      <= fields.trig;
        out_no_target <= ~|final_mask;
      end
    end
  end

  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mask) &&
      $stable(out_vector) && $stable(out_dmode) && $stable(out_trig));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  // R8
  lowpri_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dmode == DM_LOWPRI |-> $onehot0(out_mask));

  // R11
  no_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_no_target == (out_mask == '0)));

  // R7
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_kind && req_data[19:18] == 2'd2 && req_data[10:8] != DM_LOWPRI
      |=> out_mask == '1);

  // R7
  excl_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !req_kind && req_data[19:18] == 2'd3
      |=> !out_mask[$past(req_sender)]);
endmodule

// File: tb/tb_irq_route_unit.sv
`timescale 1ns/1ps
module tb_irq_route_unit;
  localparam int N = 8;
  localparam int IDXW = $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_kind, out_valid, out_ready;
  logic out_trig, out_no_target;
  logic [31:0] req_addr, req_data;
  logic [IDXW-1:0] req_sender;
  logic [8*N-1:0] agent_phys_id, agent_log_id;
  logic [4*N-1:0] agent_model;
  logic [N-1:0] out_mask;
  logic [7:0] out_vector;
  logic [2:0] out_dmode;

  int checks = 0;
  int errors = 0;

  logic [7:0] cfg_phys [N];
  logic [7:0] cfg_log  [N];
  logic [3:0] cfg_mdl  [N];

  irq_route_unit #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .req_sender(req_sender), .agent_phys_id(agent_phys_id),
    .agent_log_id(agent_log_id), .agent_model(agent_model),
    .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
    .out_vector(out_vector), .out_dmode(out_dmode), .out_trig(out_trig),
    .out_no_target(out_no_target)
  );

  function automatic logic [N-1:0] exp_mask(logic kind, logic [31:0] a, logic [31:0] d, int snd);
    logic [7:0] dst;
    logic lg;
    logic [1:0] sh;
    logic [N-1:0] m, r;
    dst = kind ? a[19:12] : a[31:24];
    lg  = kind ? a[2] : d[11];
    sh  = kind ? 2'd0 : d[19:18];
    m = '0;
    if (sh == 2'd1) m[snd] = 1'b1;
    else if (sh == 2'd2) m = '1;
    else if (sh == 2'd3) begin m = '1; m[snd] = 1'b0; end
    else if (!lg) begin
      if (dst == 8'hFF) m = '1;
      else for (int i = N-1; i >= 0; i--) if (cfg_phys[i] == dst) m = N'(1) << i;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cfg_mdl[i] == 4'hF && (dst & cfg_log[i]) != 0) m[i] = 1'b1;
        if (cfg_mdl[i] == 4'h0 && dst[7:4] == cfg_log[i][7:4] &&
            (dst[3:0] & cfg_log[i][3:0]) != 0) m[i] = 1'b1;
      end
    end
    if (d[10:8] == 3'b001) begin
      r = '0;
      for (int i = N-1; i >= 0; i--) if (m[i]) r = N'(1) << i;
      m = r;
    end
    return m;
  endfunction

  task automatic send_check(input logic kind, input logic [31:0] a, input logic [31:0] d,
                            input int snd, input string rq);
    logic [N-1:0] em;
    @(negedge clk);
    req_kind = kind; req_addr = a; req_data = d; req_sender = IDXW'(snd);
    req_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    em = exp_mask(kind, a, d, snd);
    checks++;
    if (!out_valid || out_mask !== em || out_vector !== d[7:0] || out_dmode !== d[10:8] ||
        out_trig !== d[15] || out_no_target !== (em == '0)) begin
      errors++;
      $display("FAIL %s kind=%0d a=%h d=%h: valid=%0d mask=%h vec=%h dm=%0d trig=%0d nt=%0d expected valid=1 mask=%h vec=%h dm=%0d trig=%0d nt=%0d",
               rq, kind, a, d, out_valid, out_mask, out_vector, out_dmode, out_trig,
               out_no_target, em, d[7:0], d[10:8], d[15], (em == '0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, d;
    string rq;
    for (int i = 0; i < N; i++) begin
      cfg_phys[i] = 8'(i * 3 + 1);
      cfg_log[i]  = 8'(((i % 3) << 4) | (1 << (i % 4)));
      cfg_mdl[i]  = (i == N-1) ? 4'h5 : ((i % 2) != 0 ? 4'h0 : 4'hF);
    end
    cfg_phys[6] = cfg_phys[2];
    for (int i = 0; i < N; i++) begin
      agent_phys_id[8*i +: 8] = cfg_phys[i];
      agent_log_id[8*i +: 8]  = cfg_log[i];
      agent_model[4*i +: 4]   = cfg_mdl[i];
    end
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1; req_kind = 1'b0;
    req_addr = '0; req_data = '0; req_sender = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: valid=%0d ready=%0d expected valid=0 ready=1", out_valid, req_ready);
    end
    rst_n = 1'b1;

    // command words, addressed: R3 R4 R5 R6 R8 R9 R11
    for (int dst = 0; dst < 256; dst++)
      for (int lg = 0; lg < 2; lg++)
        for (int dm = 0; dm < 2; dm++) begin
          a = {8'(dst), 24'hA5C3E1};
          d = '0;
          d[7:0] = 8'(dst) ^ 8'h5A; d[10:8] = 3'(dm); d[11] = 1'(lg); d[15] = 1'(dst);
          if (lg != 0) rq = "R5 R6 R9";
          else if (dst == 255) rq = "R3 R9";
          else rq = (dm == 1) ? "R4 R8 R11" : "R4 R11";
          send_check(1'b0, a, d, dst % N, rq);
        end

    // shorthands: R7 R8
    for (int sh = 1; sh < 4; sh++)
      for (int snd = 0; snd < N; snd++)
        for (int dm = 0; dm < 2; dm++) begin
          a = 32'h0300_0000;
          d = '0;
          d[19:18] = 2'(sh); d[10:8] = 3'(dm); d[7:0] = 8'(snd + 16 * sh); d[15] = 1'(snd);
          send_check(1'b0, a, d, snd, (dm == 1) ? "R7 R8" : "R7");
        end

    // message-signalled writes, shorthand bits set but ignored: R10 R7
    for (int dst = 0; dst < 256; dst++)
      for (int lg = 0; lg < 2; lg++) begin
        a = 32'hFEE0_0000 | (32'(dst) << 12) | (32'(lg) << 2);
        d = '0;
        d[7:0] = 8'(255 - dst); d[10:8] = 3'(dst); d[15] = 1'(lg); d[19:18] = 2'd3;
        send_check(1'b1, a, d, 5, "R10 R7");
      end

    // back-pressure: R2
    @(negedge clk);
    req_kind = 1'b0; req_addr = 32'h0400_0000; req_data = 32'h0000_0042;
    req_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_data = 32'h0008_0077;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (req_ready !== 1'b0 || out_valid !== 1'b1 || out_vector !== 8'h42 || out_mask !== 8'h02) begin
        errors++;
        $display("FAIL R2 stall: ready=%0d valid=%0d vec=%h mask=%h expected ready=0 valid=1 vec=42 mask=02",
                 req_ready, out_valid, out_vector, out_mask);
      end
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || out_vector !== 8'h77 || out_mask !== 8'hFF) begin
      errors++;
      $display("FAIL R2 drain: valid=%0d vec=%h mask=%h expected valid=1 vec=77 mask=ff",
               out_valid, out_vector, out_mask);
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: valid=%0d expected 0", out_valid);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule